// File: doc/BRIEF.md
# Serial Channel Line Status Monitor

This block watches one serial channel's receive line together with its carrier-detect and clear-to-send pins and reports a three-bit status word. The word carries a line-idle flag, a carrier flag and a clear-to-send flag. A receiver or a software poll reads it to learn whether the line has gone quiet and whether the modem control lines are asserted.

Idle detection depends on the protocol. In HDLC mode it counts a run of fifteen ones. In UART mode it counts a full idle character, whose length is programmable. Any received zero ends idle at once. In normal diagnostic mode the carrier pin gates the idle flag. Both pin flags are masked according to how the serial interface is multiplexed.

The two pins are resynchronised to the serial clock before use. Receive bits are counted only on cycles where the bit-valid strobe is high.

Top module: `sc_line_status`

## Requirements
- R1: In HDLC mode (`proto_uart`=0), `status[2]` (line idle) becomes 1 on the cycle after the 15th consecutive strobed one bit. After 14 ones it is still 0.
- R2: A strobed zero bit clears the ones count, so `status[2]` is 0 on the cycle after that strobe when line idle is not being forced by carrier gating.
- R3: In UART mode (`proto_uart`=1), idle sets after N consecutive strobed ones, where N is `char_bits`. Values below 9 act as 9 and values above 13 act as 13.
- R4: HDLC flag bytes (0111 1110) received back to back keep `status[2]` at 0.
- R5: In normal diagnostic mode (`diag_sw`=0), a deasserted synchronised carrier (low) forces `status[2]` to 1 whatever the line carries.
- R6: In software diagnostic mode (`diag_sw`=1), `status[2]` follows only the line and ignores the carrier pin.
- R7: `status[1]` equals `cd_pin` delayed by the two-flop synchronizer, so a change before edge k shows after edge k+1. It is shown only when `si_mode`=0 (non-multiplexed) and reads 0 for `si_mode` 1 (PCM highway), 2 (GCI/IDL) and 3 (reserved).
- R8: `status[0]` follows the synchronised `cts_pin` with the same polarity. This holds when `si_mode`=0, or when `si_mode`=2 with `d_chan`=1. It reads 0 in every other case.
- R9: While `rx_en` is 0, `status[2]` and `status[1]` read 0 and the ones count is cleared. Strobed ones received during that time are not counted.
- R10: While `tx_en` is 0, `status[0]` reads 0.
- R11: The ones count saturates, so a run of 30 extra ones keeps idle set. Cycles with `rx_bit_vld` low do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Received data bit |
| rx_bit_vld | input | 1 | Strobe marking `rx_bit` valid |
| proto_uart | input | 1 | 0 HDLC, 1 UART |
| diag_sw | input | 1 | 0 normal (carrier gates idle), 1 software control |
| si_mode | input | 2 | 0 non-multiplexed, 1 PCM highway, 2 GCI/IDL, 3 reserved |
| d_chan | input | 1 | Channel attached to the D channel |
| char_bits | input | 4 | UART idle character length in bits |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| cd_pin | input | 1 | Carrier-detect pin, high = asserted |
| cts_pin | input | 1 | Clear-to-send pin, high = asserted |
| status | output | 3 | {line idle, carrier detect, clear-to-send} |

## Verification
In normal diagnostic mode, a carrier-pin change and the idle gating it drives both reach the status word on the same cycle. The bench drops the carrier while the line is busy, with `diag_sw`=0. It expects the old word for one cycle after the first edge. It then expects the carrier bit to fall and the idle bit to rise together in one step. A second overlap is a strobed bit arriving in the same cycle that `rx_en` is dropped. That case is judged by the count restarting from zero once reception is enabled again.

// File: rtl/sc_line_status.sv
module sc_line_status #(
  parameter int HDLC_RUN    = 15,
  parameter int UART_MIN    = 9,
  parameter int UART_MAX    = 13,
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_bit_vld,
  input  logic             proto_uart,
  input  logic             diag_sw,
  input  logic [1:0]       si_mode,
  input  logic             d_chan,
  input  logic [LEN_W-1:0] char_bits,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             cd_pin,
  input  logic             cts_pin,
  output logic [2:0]       status
);
  localparam int RUN_MAX = (HDLC_RUN > UART_MAX) ? HDLC_RUN : UART_MAX;
  localparam int CNT_W   = $clog2(RUN_MAX + 1);

  localparam logic [1:0] SI_DIRECT = 2'd0;
  localparam logic [1:0] SI_GCI    = 2'd2;

  logic [CNT_W-1:0]       ones_q;
  logic [CNT_W-1:0]       thr;
  logic [SYNC_STAGES-1:0] cd_sync, cts_sync;
  logic                   line_quiet, cd_s, cts_s;

  always_comb begin
    if (!proto_uart)
      thr = CNT_W'(HDLC_RUN);
    else if (int'(char_bits) < UART_MIN)
      thr = CNT_W'(UART_MIN);
    else if (int'(char_bits) > UART_MAX)
      thr = CNT_W'(UART_MAX);
    else
      thr = CNT_W'(char_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ones_q <= '0;
    else if (!rx_en)
      ones_q <= '0;
    else if (rx_bit_vld) begin
      if (!rx_bit)
        ones_q <= '0;
      else if (ones_q < thr)
        ones_q <= ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_sync  <= '0;
      cts_sync <= '0;
    end else begin
      cd_sync  <= {cd_sync[SYNC_STAGES-2:0], cd_pin};
      cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_pin};
    end
  end

  assign cd_s       = cd_sync[SYNC_STAGES-1];
  assign cts_s      = cts_sync[SYNC_STAGES-1];
  assign line_quiet = (ones_q >= thr);

  assign status[2] = rx_en & (diag_sw ? line_quiet : (line_quiet | ~cd_s));
  assign status[1] = rx_en & (si_mode == SI_DIRECT) & cd_s;
  assign status[0] = tx_en & cts_s &
                     ((si_mode == SI_DIRECT) | ((si_mode == SI_GCI) & d_chan));

  AST_ZERO_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_bit_vld && !rx_bit) |=> (ones_q == '0)) else $error("zero kept count"); // R2

  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (status[2:1] == 2'b00)) else $error("rx off status"); // R9

  AST_TX_OFF_NO_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !status[0]) else $error("tx off cts"); // R10

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_bit_vld && rx_bit && (ones_q >= thr)) |=> (ones_q == $past(ones_q)))
    else $error("count wrapped"); // R11

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rx_bit_vld && $past(rx_en)) |=> $stable(ones_q)) else $error("count moved"); // R11
endmodule

// File: tb/sc_line_status_tb_top.sv
`timescale 1ns/1ps
module sc_line_status_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_bit = 0, rx_bit_vld = 0, proto_uart = 0, diag_sw = 1, d_chan = 0;
  logic [1:0] si_mode = 0;
  logic [3:0] char_bits = 4'd9;
  logic rx_en = 1, tx_en = 1, cd_pin = 1, cts_pin = 1;
  logic [2:0] status;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [2:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  sc_line_status dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
    .proto_uart(proto_uart), .diag_sw(diag_sw), .si_mode(si_mode), .d_chan(d_chan),
    .char_bits(char_bits), .rx_en(rx_en), .tx_en(tx_en), .cd_pin(cd_pin),
    .cts_pin(cts_pin), .status(status)
  );

  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (status !== it.exp) begin
        n_bad++;
        $display("FAIL %s: status=%b expected=%b", it.tag, status, it.exp);
      end
    end
  end

  task automatic expect_st(input logic [2:0] e, input string tag);
    item_t it;
    #1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic send(input logic b);
    rx_bit = b; rx_bit_vld = 1;
    @(negedge clk);
    rx_bit_vld = 0;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send(1'b1);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: status=%b expected=done", status);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    expect_st(3'b000, "reset R9");
    rst_n = 1;
    settle();
    expect_st(3'b011, "pins after reset R7 R8");

    send(1'b0); send_ones(14);
    expect_st(3'b011, "14 ones R1");
    send(1'b1);
    expect_st(3'b111, "15 ones R1");

    send_ones(30);
    expect_st(3'b111, "saturated run R11");
    rx_bit = 0; repeat (4) @(negedge clk);
    expect_st(3'b111, "no strobe ignored R11");

    send(1'b0);
    expect_st(3'b011, "zero clears R2");

    for (int f = 0; f < 4; f++) begin
      send(1'b0); send_ones(6); send(1'b0);
      expect_st(3'b011, "flags R4");
    end

    proto_uart = 1; char_bits = 4'd11;
    send(1'b0); send_ones(10);
    expect_st(3'b011, "uart 10 of 11 R3");
    send(1'b1);
    expect_st(3'b111, "uart 11 R3");
    char_bits = 4'd5;
    send(1'b0); send_ones(8);
    expect_st(3'b011, "uart clamp low 8 R3");
    send(1'b1);
    expect_st(3'b111, "uart clamp low 9 R3");
    char_bits = 4'd15;
    send(1'b0); send_ones(12);
    expect_st(3'b011, "uart clamp high 12 R3");
    send(1'b1);
    expect_st(3'b111, "uart clamp high 13 R3");

    cd_pin = 0; settle();
    expect_st(3'b101, "sw diag idle kept R6");
    send(1'b0);
    expect_st(3'b001, "sw diag busy ignores cd R6");

    diag_sw = 0;
    expect_st(3'b101, "cd low forces idle R5");
    cd_pin = 1; settle();
    expect_st(3'b011, "cd high line busy R5");

    cd_pin = 0;
    @(negedge clk);
    expect_st(3'b011, "cd sync stage one R7");
    expect_st(3'b101, "cd sync stage two R7 R5");
    cd_pin = 1; settle();

    si_mode = 2'd1;
    expect_st(3'b000, "pcm masks R7 R8");
    si_mode = 2'd2; d_chan = 0;
    expect_st(3'b000, "gci no dchan R8");
    d_chan = 1;
    expect_st(3'b001, "gci dchan R8");
    si_mode = 2'd3;
    expect_st(3'b000, "reserved R7 R8");
    si_mode = 2'd0;
    expect_st(3'b011, "direct R7");

    tx_en = 0;
    expect_st(3'b010, "tx off R10");
    tx_en = 1;
    expect_st(3'b011, "tx on R10");

    diag_sw = 1; proto_uart = 0;
    send_ones(15);
    expect_st(3'b111, "idle before rx off R9");
    rx_en = 0;
    expect_st(3'b001, "rx off R9");
    send_ones(5);
    expect_st(3'b001, "rx off ones ignored R9");
    rx_en = 1;
    expect_st(3'b011, "rx on count cleared R9");
    send_ones(14);
    expect_st(3'b011, "rerun 14 R9");
    send(1'b1);
    expect_st(3'b111, "rerun 15 R1");

    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule